// File: doc/BRIEF.md
# Channel Status Block Buffer Chain

This block moves 192-bit channel status blocks through three buffers. A receive buffer (D) is filled byte by byte from the receive side. An input-block strobe copies D into a middle buffer (E), which a host can read and overwrite through a small register port. An output-block strobe copies E into a transmit buffer (F), and the transmit side reads F by byte address. The two strobes stand for two unrelated audio timebases and arrive independently, both sampled in one system clock. If output blocks come faster than input blocks, F reloads from an unchanged E and a block goes out more than once. If they come slower, E is overwritten before F takes it and some received blocks are never sent.

Each of the two transfers has its own inhibit bit and its own sticky interrupt flag with an enable. While an inhibit bit is set, the matching strobe is thrown away. A host that wants its own data transmitted must therefore hold off D-to-E transfers while it writes E. After every E-to-F load, a small state machine walks bytes 0 to 22 of F and computes an 8-bit CRC. If the block is in professional mode, the machine writes the result into the last byte of F. The machine has three states: CRC_IDLE, CRC_RUN and CRC_PUT. Start (an accepted output strobe) goes from any state to CRC_RUN. Step stays in CRC_RUN until byte 22 has been folded in. Finish goes from CRC_RUN to CRC_PUT. Return goes from CRC_PUT to CRC_IDLE.

Top module: `csb_buffer_chain`

## Requirements
- R1: After reset, every byte of D, E and F reads 0, the control and status registers read 0, `tx_ready` is 1 and `irq` is 0.
- R2: A pulse on `in_blk_stb` while the D-to-E inhibit is clear copies all 24 bytes of D into E at that clock edge. The new E is readable on `host_rdata` in the following cycle.
- R3: A pulse on `out_blk_stb` while the E-to-F inhibit is clear copies all 24 bytes of E, as they stood before that edge, into F. Repeated output strobes with E unchanged give the same F again. Two input transfers before one output transfer leave only the second block in F.
- R4: The status register at address 25 holds flag bit 0 (D-to-E done) and flag bit 1 (E-to-F done). Each flag is set by every transfer that takes place and stays set until the host writes a 1 to that bit. A set and a clear in the same cycle leave the flag set. `irq` is high when any flag is set whose enable bit is also set.
- R5: The control register at address 24 has four bits: bit 0 inhibits D-to-E, bit 1 inhibits E-to-F, bit 2 enables the D-to-E interrupt and bit 3 enables the E-to-F interrupt. A strobe that arrives while its inhibit bit is set changes no buffer and sets no flag. It is dropped, not deferred, so clearing the inhibit bit later does not cause the transfer.
- R6: Host addresses 0 to 23 read and write E bytes 0 to 23. A host write to E in the same cycle as a D-to-E transfer is lost. Addresses above 25 read as 0.
- R7: After an accepted output strobe, `tx_ready` goes low at that edge and comes back high at the 24th clock edge after it.
- R8: When bit 0 of F byte 0 is 1 (professional mode), F byte 23 is replaced by the CRC of bytes 0 to 22. The CRC uses polynomial 0x1D, starts from 0xFF, and takes bits LSB first. Each bit is XORed with register bit 7, the register shifts left, and the polynomial is XORed in when that XOR is 1. When bit 0 of F byte 0 is 0, byte 23 is sent as loaded.
- R9: An accepted output strobe during a CRC calculation reloads F and restarts the calculation. The CRC that is placed belongs to the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_we | input | 1 | Write strobe for the receive buffer D |
| rx_addr | input | 5 | D byte address |
| rx_data | input | 8 | D byte data |
| in_blk_stb | input | 1 | Input-timebase block strobe (D to E) |
| out_blk_stb | input | 1 | Output-timebase block strobe (E to F) |
| host_we | input | 1 | Host register write |
| host_addr | input | 5 | Host address: 0-23 E bytes, 24 control, 25 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| tx_addr | input | 5 | F byte address for the transmit side |
| tx_data | output | 8 | F byte at `tx_addr` |
| tx_ready | output | 1 | High when no CRC calculation is pending |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default of 24 bytes. At that size the full 192-bit block, the CRC over bytes 0 to 22 and the exact 24-cycle calculation latency are all checked. A table of byte patterns, some with the mode bit set and some without, drives the D to E to F path. Directed sequences then cover block repetition and dropping, inhibits that discard strobes, write collisions, flag set/clear races and a restart of the calculation part way through.

// File: rtl/csb_pkg.sv
package csb_pkg;

    localparam logic [7:0] CRC_POLY = 8'h1D;
    localparam logic [7:0] CRC_SEED = 8'hFF;

    typedef enum logic [1:0] {
        CRC_IDLE = 2'd0,
        CRC_RUN  = 2'd1,
        CRC_PUT  = 2'd2
    } crc_state_e;

    typedef struct packed {
        logic ie_ef;
        logic ie_de;
        logic inh_ef;
        logic inh_de;
    } ctrl_t;

    // Fold one byte into the CRC register, least significant bit first.
    function automatic logic [7:0] crc_fold(input logic [7:0] c_in, input logic [7:0] data);
        logic [7:0] c;
        logic       fb;
        c = c_in;
        for (int k = 0; k < 8; k++) begin
            fb = c[7] ^ data[k];
            c  = {c[6:0], 1'b0};
            if (fb) begin
                c = c ^ CRC_POLY;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/csb_ctrl.sv
module csb_ctrl
    import csb_pkg::*;
#(
    parameter int AW        = 5,
    parameter int CTRL_ADDR = 24,
    parameter int STAT_ADDR = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    input  logic          de_done,
    input  logic          ef_done,
    output ctrl_t         ctrl,
    output logic [1:0]    flags,
    output logic          irq
);

    ctrl_t      ctrl_q;
    logic [1:0] flag_q;
    logic [1:0] flag_d;
    logic [1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (host_we && host_addr == AW'(STAT_ADDR)) begin
            clr_mask = host_wdata[1:0];
        end
        // a transfer in the same cycle as a clear keeps its flag
        flag_d = (flag_q & ~clr_mask) | {ef_done, de_done};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            flag_q <= '0;
        end else begin
            if (host_we && host_addr == AW'(CTRL_ADDR)) begin
                ctrl_q <= ctrl_t'(host_wdata[3:0]);
            end
            flag_q <= flag_d;
        end
    end

    assign ctrl  = ctrl_q;
    assign flags = flag_q;
    assign irq   = |(flag_q & {ctrl_q.ie_ef, ctrl_q.ie_de});

endmodule

// File: rtl/csb_crc_fsm.sv
module csb_crc_fsm
    import csb_pkg::*;
#(
    parameter int NB = 24,
    localparam int IW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    byte_in,
    input  logic          pro,
    output logic [IW-1:0] rd_idx,
    output logic          ready,
    output logic          put_en,
    output logic [7:0]    put_val
);

    localparam int LAST = NB - 2;

    crc_state_e    st_q, st_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [7:0]    crc_q, crc_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CRC_IDLE;
            idx_q <= '0;
            crc_q <= CRC_SEED;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            crc_q <= crc_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        crc_d = crc_q;
        if (start) begin
            st_d  = CRC_RUN;
            idx_d = '0;
            crc_d = CRC_SEED;
        end else begin
            unique case (st_q)
                CRC_IDLE: begin
                    st_d = CRC_IDLE;
                end
                CRC_RUN: begin
                    crc_d = crc_fold(crc_q, byte_in);
                    if (idx_q == IW'(LAST)) begin
                        st_d = CRC_PUT;
                    end else begin
                        idx_d = idx_q + IW'(1);
                    end
                end
                CRC_PUT: begin
                    st_d = CRC_IDLE;
                end
                default: begin
                    st_d = CRC_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_idx  = idx_q;
        ready   = (st_q == CRC_IDLE);
        put_en  = (st_q == CRC_PUT) && pro;
        put_val = crc_q;
    end

endmodule

// File: rtl/csb_buffer_chain.sv
module csb_buffer_chain
    import csb_pkg::*;
#(
    parameter int BYTES = 24,
    localparam int AW = $clog2(BYTES + 2),
    localparam int IW = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_we,
    input  logic [IW-1:0] rx_addr,
    input  logic [7:0]    rx_data,
    input  logic          in_blk_stb,
    input  logic          out_blk_stb,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic [IW-1:0] tx_addr,
    output logic [7:0]    tx_data,
    output logic          tx_ready,
    output logic          irq
);

    localparam int CTRL_ADDR = BYTES;
    localparam int STAT_ADDR = BYTES + 1;

    logic [BYTES-1:0][7:0] d_q;
    logic [BYTES-1:0][7:0] e_q;
    logic [BYTES-1:0][7:0] f_q;

    ctrl_t         ctrl;
    logic [1:0]    flags;
    logic          de_go;
    logic          ef_go;
    logic          host_e_we;
    logic [IW-1:0] crc_idx;
    logic          put_en;
    logic [7:0]    put_val;

    assign de_go     = in_blk_stb  && !ctrl.inh_de;
    assign ef_go     = out_blk_stb && !ctrl.inh_ef;
    assign host_e_we = host_we && (int'(host_addr) < BYTES);

    csb_ctrl #(
        .AW        (AW),
        .CTRL_ADDR (CTRL_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .de_done    (de_go),
        .ef_done    (ef_go),
        .ctrl       (ctrl),
        .flags      (flags),
        .irq        (irq)
    );

    csb_crc_fsm #(
        .NB (BYTES)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ef_go),
        .byte_in (f_q[crc_idx]),
        .pro     (f_q[0][0]),
        .rd_idx  (crc_idx),
        .ready   (tx_ready),
        .put_en  (put_en),
        .put_val (put_val)
    );

    // receive stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else if (rx_we && (int'(rx_addr) < BYTES)) begin
            d_q[rx_addr] <= rx_data;
        end
    end

    // host-visible stage: a block transfer wins over a host byte write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else if (de_go) begin
            e_q <= d_q;
        end else if (host_e_we) begin
            e_q[host_addr[IW-1:0]] <= host_wdata;
        end
    end

    // transmit stage: a reload wins over the CRC write-back
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else if (ef_go) begin
            f_q <= e_q;
        end else if (put_en) begin
            f_q[BYTES-1] <= put_val;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (int'(host_addr) < BYTES) begin
            host_rdata = e_q[host_addr[IW-1:0]];
        end else if (host_addr == AW'(CTRL_ADDR)) begin
            host_rdata = {4'b0, ctrl};
        end else if (host_addr == AW'(STAT_ADDR)) begin
            host_rdata = {6'b0, flags};
        end
    end

    assign tx_data = (int'(tx_addr) < BYTES) ? f_q[tx_addr] : 8'h00;

endmodule

// File: rtl/csb_chain_checker.sv
module csb_chain_checker #(
    parameter int BYTES = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_blk_stb,
    input logic                  out_blk_stb,
    input logic                  host_e_we,
    input logic                  inh_de,
    input logic                  inh_ef,
    input logic [BYTES-1:0][7:0] d_q,
    input logic [BYTES-1:0][7:0] e_q,
    input logic [BYTES-1:0][7:0] f_q,
    input logic [1:0]            flags,
    input logic                  tx_ready
);

    // R2 / R6: an accepted input strobe loads E from D, even over a host write
    p_de_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blk_stb && !inh_de) |=> (e_q == $past(d_q)));

    // R5: inhibited input strobe leaves E alone
    p_de_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blk_stb && inh_de && !host_e_we) |=> $stable(e_q));

    // R3: accepted output strobe loads F from the previous E
    p_ef_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_blk_stb && !inh_ef) |=> (f_q == $past(e_q)));

    // R5: inhibited output strobe while idle leaves F alone
    p_ef_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_blk_stb && inh_ef && tx_ready) |=> $stable(f_q));

    // R4: each accepted transfer sets its flag
    p_de_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blk_stb && !inh_de) |=> flags[0]);

    p_ef_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_blk_stb && !inh_ef) |=> flags[1]);

    // R7: calculation starts right after the load
    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_blk_stb && !inh_ef) |=> !tx_ready);

    // R8: with no calculation pending and no load, F holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !(out_blk_stb && !inh_ef)) |=> $stable(f_q));

endmodule

bind csb_buffer_chain csb_chain_checker #(.BYTES(BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_blk_stb  (in_blk_stb),
    .out_blk_stb (out_blk_stb),
    .host_e_we   (host_e_we),
    .inh_de      (ctrl.inh_de),
    .inh_ef      (ctrl.inh_ef),
    .d_q         (d_q),
    .e_q         (e_q),
    .f_q         (f_q),
    .flags       (flags),
    .tx_ready    (tx_ready)
);

// File: tb/csb_buffer_chain_test.sv
module csb_buffer_chain_test;

    localparam int NB   = 24;
    localparam int AW   = 5;
    localparam int IW   = 5;
    localparam int CTRL = 24;
    localparam int STAT = 25;
    localparam int NV   = 6;
    // {seed, step}: byte i = seed + i*step; seed bit 0 selects professional mode
    localparam logic [15:0] VEC [NV] = '{16'h0100, 16'h0011, 16'hA53C,
                                         16'hFFFF, 16'h4007, 16'h035A};

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rx_we, in_blk_stb, out_blk_stb, host_we;
    logic [IW-1:0] rx_addr, tx_addr;
    logic [7:0]    rx_data, host_wdata;
    logic [AW-1:0] host_addr;
    logic [7:0]    host_rdata, tx_data;
    logic          tx_ready, irq;

    int checks = 0;
    int errors = 0;
    logic [NB-1:0][7:0] blk_a, blk_b, exp_f;
    logic [7:0] rv;
    int lat;

    always #4 clk = ~clk;

    csb_buffer_chain uut (
        .clk(clk), .rst_n(rst_n), .rx_we(rx_we), .rx_addr(rx_addr), .rx_data(rx_data),
        .in_blk_stb(in_blk_stb), .out_blk_stb(out_blk_stb), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_addr(tx_addr), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NB-1:0][7:0] make_blk(input logic [7:0] seed, input logic [7:0] step);
        logic [NB-1:0][7:0] b;
        for (int i = 0; i < NB; i++) b[i] = seed + 8'(i) * step;
        return b;
    endfunction

    function automatic logic [7:0] ref_crc(input logic [NB-1:0][7:0] b);
        logic [7:0] r = 8'hFF;
        logic x;
        for (int i = 0; i < NB - 1; i++) begin
            for (int k = 0; k < 8; k++) begin
                x = r[7] ^ b[i][k];
                r = x ? ({r[6:0], 1'b0} ^ 8'h1D) : {r[6:0], 1'b0};
            end
        end
        return r;
    endfunction

    function automatic logic [NB-1:0][7:0] tx_view(input logic [NB-1:0][7:0] b);
        logic [NB-1:0][7:0] t = b;
        if (b[0][0]) t[NB-1] = ref_crc(b);
        return t;
    endfunction

    task automatic load_d(input logic [NB-1:0][7:0] b);
        for (int i = 0; i < NB; i++) begin
            @(negedge clk); rx_we = 1'b1; rx_addr = IW'(i); rx_data = b[i];
        end
        @(negedge clk); rx_we = 1'b0;
    endtask

    task automatic pulse_in();
        @(negedge clk); in_blk_stb = 1'b1;
        @(negedge clk); in_blk_stb = 1'b0;
    endtask

    task automatic pulse_out();
        @(negedge clk); out_blk_stb = 1'b1;
        @(negedge clk); out_blk_stb = 1'b0;
    endtask

    task automatic hwr(input int a, input logic [7:0] v);
        @(negedge clk); host_we = 1'b1; host_addr = AW'(a); host_wdata = v;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic hrd(input int a, output logic [7:0] v);
        host_addr = AW'(a); #1; v = host_rdata;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!tx_ready && n < 100) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic check_f(input string req, input logic [NB-1:0][7:0] exp);
        int bad = -1;
        for (int i = 0; i < NB; i++) begin
            tx_addr = IW'(i); #1;
            if (tx_data !== exp[i] && bad < 0) bad = i;
        end
        if (bad < 0) check(req, 0, 0);
        else begin
            tx_addr = IW'(bad); #1;
            check($sformatf("%s byte %0d", req, bad), {24'b0, tx_data}, {24'b0, exp[bad]});
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_we = 0; in_blk_stb = 0; out_blk_stb = 0; host_we = 0;
        rx_addr = '0; rx_data = '0; host_addr = '0; host_wdata = '0; tx_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hrd(0, rv);    check("R1 E byte 0", rv, 0);
        hrd(CTRL, rv); check("R1 control", rv, 0);
        hrd(STAT, rv); check("R1 status", rv, 0);
        check("R1 tx_ready", tx_ready, 1);
        check("R1 irq", irq, 0);
        check_f("R1 F cleared", '0);

        // table walk: R2, R3, R8
        for (int v = 0; v < NV; v++) begin
            blk_a = make_blk(VEC[v][15:8], VEC[v][7:0]);
            load_d(blk_a);
            pulse_in();
            hrd(5, rv); check("R2 E byte 5 after transfer", rv, blk_a[5]);
            pulse_out();
            wait_ready(lat);
            check_f($sformatf("R3/R8 vector %0d", v), tx_view(blk_a));
        end

        // R7 latency of the last calculation
        check("R7 ready latency", lat, 24);

        // R3 repeat: E unchanged, F reloads the same block
        hwr(STAT, 8'h03);
        pulse_out(); wait_ready(lat);
        check_f("R3 repeated block", tx_view(blk_a));
        hrd(STAT, rv); check("R4 E-to-F flag", rv, 8'h02);

        // R3 drop: two input blocks, one output block
        blk_a = make_blk(8'h10, 8'h03);
        blk_b = make_blk(8'h21, 8'h05);
        load_d(blk_a); pulse_in();
        load_d(blk_b); pulse_in();
        pulse_out(); wait_ready(lat);
        check_f("R3 dropped block", tx_view(blk_b));

        // R4 interrupt enable and clear
        hwr(STAT, 8'h03);
        hrd(STAT, rv); check("R4 flags cleared", rv, 0);
        hwr(CTRL, 8'h04);
        pulse_in();
        check("R4 irq on D-to-E", irq, 1);
        hwr(STAT, 8'h01);
        check("R4 irq after clear", irq, 0);
        @(negedge clk); in_blk_stb = 1; host_we = 1; host_addr = AW'(STAT); host_wdata = 8'h01;
        @(negedge clk); in_blk_stb = 0; host_we = 0;
        hrd(STAT, rv); check("R4 set wins over clear", rv, 8'h01);
        hwr(CTRL, 8'h08);
        check("R4 irq masked", irq, 0);

        // R5 D-to-E inhibit, not deferred
        hwr(CTRL, 8'h01);
        hwr(STAT, 8'h03);
        load_d(blk_a);
        pulse_in();
        hrd(2, rv); check("R5 E unchanged under inhibit", rv, blk_b[2]);
        hrd(STAT, rv); check("R5 no flag under inhibit", rv, 0);
        hwr(CTRL, 8'h00);
        repeat (3) @(negedge clk);
        hrd(2, rv); check("R5 strobe not deferred", rv, blk_b[2]);

        // R5 E-to-F inhibit
        hwr(CTRL, 8'h02);
        hwr(4, 8'hC7);
        pulse_out();
        check_f("R5 F unchanged under inhibit", tx_view(blk_b));
        hrd(STAT, rv); check("R5 no E-to-F flag", rv, 0);
        hwr(CTRL, 8'h00);

        // R6 host access and collision
        hwr(7, 8'h5E);
        hrd(7, rv); check("R6 host E write", rv, 8'h5E);
        hrd(30, rv); check("R6 unused address", rv, 0);
        @(negedge clk); in_blk_stb = 1; host_we = 1; host_addr = AW'(3); host_wdata = 8'hAA;
        @(negedge clk); in_blk_stb = 0; host_we = 0;
        hrd(3, rv); check("R6 transfer wins collision", rv, blk_a[3]);

        // R9 restart during a calculation; E now holds blk_a (professional: seed 0x10 is consumer)
        blk_b = make_blk(8'h31, 8'h0B);
        load_d(blk_b); pulse_in();
        pulse_out();
        repeat (5) @(negedge clk);
        check("R9 busy mid calculation", tx_ready, 0);
        hwr(10, 8'h77);
        exp_f = blk_b; exp_f[10] = 8'h77;
        pulse_out(); wait_ready(lat);
        check("R9 restart latency", lat, 24);
        check_f("R9 CRC of reloaded block", tx_view(exp_f));

        // R8 consumer block keeps byte 23 as loaded
        blk_a = make_blk(8'h00, 8'h09);
        load_d(blk_a); pulse_in(); pulse_out(); wait_ready(lat);
        tx_addr = IW'(NB - 1); #1;
        check("R8 consumer byte 23", tx_data, blk_a[NB-1]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule